// File: doc/BRIEF.md
# Configurable Combinational-Sequential Logic Cell

This block is one programmable cell of a logic array. A four-way data multiplexer forms the combinational result. Its upper select term is the OR of one pair of gating inputs and its lower select term is the AND of a second pair. The result then goes to one of two places. It can drive the output directly in pass-through mode. Otherwise it enters a storage element, which configuration sets to act as a transparent latch or as a rising-edge flip-flop.

The storage element takes its clock from one of three global clock inputs through a configuration selector. A fourth selector code holds that clock low. An active-high clear input from general routing empties the storage at any time. The chip-level active-low reset does the same. Because the multiplexer and the storage sit in one cell, a function followed by a register costs no extra cell.

Top module: `lcell`

## Requirements
- R1: With the bypass bit at 1, y_o equals d_i[{a1_i|b1_i, a0_i&b0_i}]. Bit 0 of d_i is taken for select value 0, bit 1 for 1, bit 2 for 2 and bit 3 for 3.
- R2: With the bypass bit at 1, y_o follows changes of the data and gating inputs without any clock edge.
- R3: With cfg_latch_i at 0 (flip-flop) and bypass at 0, y_o takes the combinational result on each rising edge of the selected clock and holds it at all other times.
- R4: With cfg_latch_i at 1 (latch) and bypass at 0, y_o follows the combinational result while the selected clock is high. It holds the last value while that clock is low.
- R5: cfg_clk_sel_i selects the clock: code 0 selects gclk_i[0], code 1 gclk_i[1] and code 2 gclk_i[2]. Code 3 holds the storage clock low, so the flip-flop never captures and the latch stays closed.
- R6: clr_i at 1 forces the stored value to 0 at once and without a clock, in both latch and flip-flop modes.
- R7: rst_ni at 0 clears the storage in the same way as clr_i.
- R8: Edges on the two clock inputs that are not selected have no effect on y_o.
- R9: In bypass mode clr_i has no effect on y_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Chip reset, active low, asynchronous |
| gclk_i | input | 3 | Global clock networks; bit k is selected by code k |
| clr_i | input | 1 | Storage clear from routing, active high, asynchronous |
| d_i | input | 4 | Multiplexer data inputs, indexed by select value |
| a0_i | input | 1 | Low select term gating input (AND) |
| b0_i | input | 1 | Low select term gating input (AND) |
| a1_i | input | 1 | High select term gating input (OR) |
| b1_i | input | 1 | High select term gating input (OR) |
| cfg_clk_sel_i | input | 2 | Clock select code; 3 = clock held low |
| cfg_latch_i | input | 1 | 1 = latch, 0 = flip-flop |
| cfg_bypass_i | input | 1 | 1 = combinational result to output |
| y_o | output | 1 | Cell output |

## Verification
Some clock edges are not real clock edges. A storage clock edge can come from a change of the select code while the newly chosen network is already high. A clear can be released while the latch clock is high, so the latch turns transparent with no edge at all. Both cases are hard to reach on purpose. The random stimulus therefore changes the data inputs, the configuration, the clear and single clock levels in separate steps, and clocks are left high between steps. A bench model tracks the selected clock level and updates itself on every step, so the cases above occur often and each one is checked when it happens.

// File: rtl/lcell_pkg.sv
package lcell_pkg;
  localparam int unsigned NUM_GCLK = 3;
  localparam int unsigned CSEL_W   = $clog2(NUM_GCLK + 1);
  localparam int unsigned SEL_W    = 2;
  localparam int unsigned DATA_N   = 1 << SEL_W;

  typedef enum logic {
    STORE_FLOP  = 1'b0,
    STORE_LATCH = 1'b1
  } store_mode_e;
endpackage

// File: rtl/lcell_mux.sv
module lcell_mux
  import lcell_pkg::*;
(
  input  logic [DATA_N-1:0] d_i,
  input  logic              a0_i,
  input  logic              b0_i,
  input  logic              a1_i,
  input  logic              b1_i,
  output logic              f_o
);
  logic [SEL_W-1:0] sel;

  always_comb begin
    sel = {a1_i | b1_i, a0_i & b0_i};
    f_o = d_i[sel];
  end
endmodule

// File: rtl/lcell_clk_sel.sv
module lcell_clk_sel
  import lcell_pkg::*;
(
  input  logic                rst_ni,
  input  logic [NUM_GCLK-1:0] gclk_i,
  input  logic [CSEL_W-1:0]   sel_i,
  output logic                gate_o
);
  logic [NUM_GCLK-1:0] en_oh;

  for (genvar k = 0; k < NUM_GCLK; k++) begin : g_dec
    assign en_oh[k] = (sel_i == CSEL_W'(k));
  end

  assign gate_o = |(en_oh & gclk_i);

  always_comb begin
    a_sel_onehot_r5: assert ($onehot0(en_oh))
      else $error("clock select enables not one-hot");
  end

  // R5: codes past the last network keep the storage clock low
  p_gate_off_r5: assert property (@(posedge gclk_i[0]) disable iff (!rst_ni)
    (sel_i >= CSEL_W'(NUM_GCLK)) |-> !gate_o)
    else $error("storage clock active with select off");
endmodule

// File: rtl/lcell_store.sv
module lcell_store (
  input  logic gate_i,
  input  logic clr_i,
  input  logic d_i,
  output logic q_ff_o,
  output logic q_lat_o
);
  always_ff @(posedge gate_i or posedge clr_i) begin
    if (clr_i) q_ff_o <= 1'b0;
    else       q_ff_o <= d_i;
  end

  always_latch begin
    if (clr_i)       q_lat_o = 1'b0;
    else if (gate_i) q_lat_o = d_i;
  end

  // R4: just before the latch closes it shows its input
  p_lat_open_r4: assert property (@(negedge gate_i) disable iff (clr_i)
    1'b1 |-> (q_lat_o == d_i))
    else $error("latch not transparent at close");

  // R6: both storage variants are empty while clear is held
  p_clear_r6: assert property (@(negedge clr_i)
    1'b1 |-> (!q_ff_o && !q_lat_o))
    else $error("storage not cleared");
endmodule

// File: rtl/lcell.sv
module lcell
  import lcell_pkg::*;
(
  input  logic                rst_ni,
  input  logic [NUM_GCLK-1:0] gclk_i,
  input  logic                clr_i,
  input  logic [DATA_N-1:0]   d_i,
  input  logic                a0_i,
  input  logic                b0_i,
  input  logic                a1_i,
  input  logic                b1_i,
  input  logic [CSEL_W-1:0]   cfg_clk_sel_i,
  input  logic                cfg_latch_i,
  input  logic                cfg_bypass_i,
  output logic                y_o
);
  logic        f;
  logic        gate;
  logic        clr_int;
  logic        q_ff, q_lat;
  store_mode_e mode;

  assign clr_int = clr_i | ~rst_ni;
  assign mode    = store_mode_e'(cfg_latch_i);

  lcell_mux u_mux (
    .d_i  (d_i),
    .a0_i (a0_i),
    .b0_i (b0_i),
    .a1_i (a1_i),
    .b1_i (b1_i),
    .f_o  (f)
  );

  lcell_clk_sel u_clk_sel (
    .rst_ni (rst_ni),
    .gclk_i (gclk_i),
    .sel_i  (cfg_clk_sel_i),
    .gate_o (gate)
  );

  lcell_store u_store (
    .gate_i  (gate),
    .clr_i   (clr_int),
    .d_i     (f),
    .q_ff_o  (q_ff),
    .q_lat_o (q_lat)
  );

  always_comb begin
    if (cfg_bypass_i)              y_o = f;
    else if (mode == STORE_LATCH)  y_o = q_lat;
    else                           y_o = q_ff;
  end

  // R6/R7: a registered output is zero while clear or reset is held
  p_out_cleared_r6: assert property (@(negedge clr_int)
    !cfg_bypass_i |-> !y_o)
    else $error("registered output not cleared");
endmodule

// File: tb/lcell_tb.sv
`timescale 1ns/1ps
module lcell_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b1;
  logic [2:0] gclk = 3'b000;
  logic       clr = 1'b0;
  logic [3:0] d = 4'b0000;
  logic       a0 = 1'b0, b0 = 1'b0, a1 = 1'b0, b1 = 1'b0;
  logic [1:0] csel = 2'd0;
  logic       latch = 1'b0;
  logic       bypass = 1'b0;
  logic       y;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  bit          done = 1'b0;

  logic m_ff = 1'b0, m_lat = 1'b0, prev_g = 1'b0;

  always #5 clk = ~clk;

  lcell u_dut (
    .rst_ni        (rst_ni),
    .gclk_i        (gclk),
    .clr_i         (clr),
    .d_i           (d),
    .a0_i          (a0),
    .b0_i          (b0),
    .a1_i          (a1),
    .b1_i          (b1),
    .cfg_clk_sel_i (csel),
    .cfg_latch_i   (latch),
    .cfg_bypass_i  (bypass),
    .y_o           (y)
  );

  function automatic logic comb_f(logic [3:0] dv, logic xa0, logic xb0,
                                  logic xa1, logic xb1);
    int idx;
    idx = ((xa1 | xb1) ? 2 : 0) + ((xa0 & xb0) ? 1 : 0);
    return dv[idx];
  endfunction

  function automatic logic gate_f(logic [1:0] s, logic [2:0] g);
    case (s)
      2'd0: return g[0];
      2'd1: return g[1];
      2'd2: return g[2];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic exp_f();
    if (bypass) return comb_f(d, a0, b0, a1, b1);
    return latch ? m_lat : m_ff;
  endfunction

  task automatic check(string tag, logic exp);
    n_chk++;
    if (y !== exp) begin
      n_bad++;
      $display("FAIL %s: y_o=%b expected %b", tag, y, exp);
    end
  endtask

  // wait for the design, then advance the model by one stimulus step
  task automatic settle();
    logic g, c;
    #2;
    g = gate_f(csel, gclk);
    c = comb_f(d, a0, b0, a1, b1);
    if (clr || !rst_ni) begin
      m_ff = 1'b0;
      m_lat = 1'b0;
    end else begin
      if (g && !prev_g) m_ff = c;
      if (g) m_lat = c;
    end
    prev_g = g;
  endtask

  task automatic step_check(string tag);
    settle();
    check(tag, exp_f());
  endtask

  task automatic pulse(int k, string tag);
    gclk[k] = 1'b1;
    step_check(tag);
    gclk[k] = 1'b0;
    step_check(tag);
  endtask

  function automatic string mode_tag();
    if (bypass) return "R2";
    if (csel == 2'd3) return "R5";
    return latch ? "R4" : "R3";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    #1;
    rst_ni = 1'b0;
    settle();
    check("R7", 1'b0);
    d = 4'b1111;
    pulse(0, "R7");
    check("R7", 1'b0);
    rst_ni = 1'b1;
    step_check("R7");

    // R1: every gating combination in bypass
    bypass = 1'b1;
    for (int v = 0; v < 16; v++) begin
      {a1, b1, a0, b0} = 4'(v);
      for (int k = 0; k < 4; k++) begin
        d = 4'b0001 << k;
        settle();
        check("R1", ((((v >> 3) | (v >> 2)) & 1) * 2 + (((v >> 1) & v) & 1)) == k);
      end
    end

    // R9: clear ignored in bypass
    d = 4'b0100; a1 = 1'b1; b1 = 1'b0; a0 = 1'b1; b0 = 1'b0;
    clr = 1'b1;
    step_check("R9");
    check("R9", 1'b1);
    clr = 1'b0;
    step_check("R9");

    // R3: flip-flop on network 0
    bypass = 1'b0; latch = 1'b0; csel = 2'd0;
    step_check("R3");
    check("R3", 1'b0);
    pulse(0, "R3");
    check("R3", 1'b1);
    d = 4'b0000;
    step_check("R3");
    check("R3", 1'b1);

    // R8: unselected networks ignored
    pulse(1, "R8");
    pulse(2, "R8");
    check("R8", 1'b1);

    // R5: select off, then network 1
    csel = 2'd3;
    step_check("R5");
    pulse(0, "R5"); pulse(1, "R5"); pulse(2, "R5");
    check("R5", 1'b1);
    csel = 2'd1;
    step_check("R5");
    pulse(1, "R5");
    check("R5", 1'b0);

    // R4: latch on network 2
    latch = 1'b1; csel = 2'd2;
    gclk[2] = 1'b1;
    step_check("R4");
    d = 4'b0100;
    step_check("R4");
    check("R4", 1'b1);
    gclk[2] = 1'b0;
    step_check("R4");
    d = 4'b0000;
    step_check("R4");
    check("R4", 1'b1);

    // R6: clear in both modes, release while transparent
    gclk[2] = 1'b1;
    d = 4'b0100;
    step_check("R4");
    clr = 1'b1;
    step_check("R6");
    check("R6", 1'b0);
    clr = 1'b0;
    step_check("R6");
    check("R6", 1'b1);
    gclk[2] = 1'b0;
    step_check("R4");
    latch = 1'b0;
    csel = 2'd0;
    pulse(0, "R3");
    clr = 1'b1;
    step_check("R6");
    check("R6", 1'b0);
    clr = 1'b0;
    step_check("R6");

    // random mix, one kind of change per step
    for (int i = 0; i < 3000; i++) begin
      case ($urandom_range(0, 9))
        0, 1, 2: begin
          d = 4'($urandom);
          {a0, b0, a1, b1} = 4'($urandom);
          step_check(mode_tag());
        end
        3: begin
          csel = 2'($urandom);
          latch = 1'($urandom);
          bypass = ($urandom_range(0, 3) == 0);
          step_check(mode_tag());
        end
        4: begin
          clr = ~clr;
          step_check(bypass ? "R9" : "R6");
        end
        5: begin
          rst_ni = ($urandom_range(0, 7) != 0);
          step_check("R7");
        end
        default: begin
          int k;
          k = $urandom_range(0, 2);
          gclk[k] = ~gclk[k];
          step_check((csel == 2'(k)) ? mode_tag() : "R8");
        end
      endcase
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule